// File: doc/BRIEF.md
# Timing Wheel Cell Resequencer

This block puts cells that leave a load-balanced multistage switch fabric back into timestamp order before they reach the output buffer. Each arriving cell descriptor carries a cell identifier and a timestamp taken from a system-wide time base. The descriptor is appended to one of `SLOTS` slot lists. The slot is chosen by the timestamp modulo `SLOTS`. Every slot list is a linked list kept in one shared descriptor memory.

A `tick_i` pulse advances the local time by one. On that cycle the slot for the new time is spliced as a whole onto the tail of a ready list in one operation. The slot is then cleared. The ready list drains one cell per cycle into a registered valid/ready output stream. Released descriptors go back to a recycled pool.

Cells arriving too late for their slot are handled according to `loose_i`. In strict mode (`loose_i` = 0) they are discarded. In loose mode (`loose_i` = 1) they are delayed by one more wheel turn. Cells that are too late even for that are discarded in both modes, and so are cells stamped in the future. A discarded cell produces a one-cycle pulse on `drop_o`.

Top module: `timing_wheel_reseq`

## Requirements
- R1: After reset, `out_valid` = 0, `drop_o` = 0, `overflow_o` = 0 and `in_ready` = 1 while `tick_i` = 0.
- R2: Define age = now − ts modulo 2^`TS_W`, where now is the count of ticks since reset. An accepted cell with 0 ≤ age < `SLOTS` is first presented on the output only after the tick that makes now = ts + `SLOTS`, and never earlier.
- R3: Released cells leave in ascending release time. Cells sharing a release time leave in the order they were accepted.
- R4: In strict mode, an accepted cell with `SLOTS` ≤ age < 2·`SLOTS` is discarded. `drop_o` is high in the cycle after acceptance, and the cell never appears on the output.
- R5: In loose mode, an accepted cell with `SLOTS` ≤ age < 2·`SLOTS` is kept with release time ts + 2·`SLOTS`. It leaves after every cell accepted earlier with the same release time.
- R6: An accepted cell with age ≥ 2·`SLOTS`, which includes a future timestamp because it wraps to a large age, is discarded in both modes with a `drop_o` pulse.
- R7: When `DEPTH` kept cells are held, a further arrival that would be kept is still accepted but discarded. Both `drop_o` and `overflow_o` are high in the next cycle, and the held cells are unaffected.
- R8: Descriptors of cells that have left the output are reused, so a run may pass more than `DEPTH` cells in total.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_id` stays unchanged.
- R10: In a cycle with `tick_i` = 1, `in_ready` is 0 and no arrival is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Advance local time by one and release the matching slot |
| loose_i | input | 1 | 1: delay late cells one wheel turn; 0: discard them |
| in_valid | input | 1 | Arrival descriptor valid |
| in_ready | output | 1 | Arrival accepted this cycle when high with in_valid |
| in_id | input | ID_W | Arriving cell identifier |
| in_ts | input | TS_W | Arriving cell timestamp |
| out_valid | output | 1 | Released cell identifier valid |
| out_ready | input | 1 | Downstream takes the released cell |
| out_id | output | ID_W | Released cell identifier |
| drop_o | output | 1 | One-cycle pulse: the last accepted cell was discarded |
| overflow_o | output | 1 | One-cycle pulse: the discard was caused by no free descriptor |

## Verification
The bench targets the age boundaries exactly at `SLOTS` − 1, `SLOTS`, 2·`SLOTS` − 1 and 2·`SLOTS`, plus negative ages. A classifier off by one would release a cell one wheel turn early, or drop one it should keep. It also mixes a loose-mode late cell into a slot that already holds on-time cells. A splice that prepended instead of appending would send the late cell out first. It fills the descriptor store to the last entry and then reuses recycled entries; a broken free pool would lose or duplicate identifiers. Finally it stalls the output across a release, where a design that popped without a handshake would skip a cell or change `out_id` under a stall.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Arrival classification by age relative to the wheel size
  typedef enum logic [1:0] {
    AGE_ONTIME = 2'd0,  // age < SLOTS: goes to its own slot
    AGE_LATE   = 2'd1,  // SLOTS <= age < 2*SLOTS: loose mode delays it
    AGE_LOST   = 2'd2   // anything else: always discarded
  } age_cls_t;
endpackage

// File: rtl/rsq_age_class.sv
module rsq_age_class #(
  parameter int TS_W  = 6,
  parameter int SLOTS = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [TS_W-1:0]   now,
  input  logic [TS_W-1:0]   ts,
  output rsq_pkg::age_cls_t cls,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [TS_W-1:0] ONE_TURN = TS_W'(SLOTS);
  localparam logic [TS_W-1:0] TWO_TURN = TS_W'(2 * SLOTS);

  logic [TS_W-1:0] age;

  always_comb begin
    age = now - ts;
    if (age < ONE_TURN)      cls = rsq_pkg::AGE_ONTIME;
    else if (age < TWO_TURN) cls = rsq_pkg::AGE_LATE;
    else                     cls = rsq_pkg::AGE_LOST;
  end

  // A late cell lands one turn later, which is the same slot index
  assign slot = ts[SLOT_W-1:0];
endmodule

// File: rtl/rsq_desc_mem.sv
module rsq_desc_mem #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             id_we,
  input  logic [PTR_W-1:0] id_wa,
  input  logic [ID_W-1:0]  id_wd,
  input  logic             nx_we,
  input  logic [PTR_W-1:0] nx_wa,
  input  logic [PTR_W-1:0] nx_wd,
  input  logic [PTR_W-1:0] ra,
  output logic [ID_W-1:0]  rd_id,
  output logic [PTR_W-1:0] rd_nx
);
  // One write port and one asynchronous read port per array (distributed RAM)
  logic [ID_W-1:0]  id_mem [DEPTH];
  logic [PTR_W-1:0] nx_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (id_we) id_mem[id_wa] <= id_wd;
  end

  always_ff @(posedge clk) begin
    if (nx_we) nx_mem[nx_wa] <= nx_wd;
  end

  assign rd_id = id_mem[ra];
  assign rd_nx = nx_mem[ra];
endmodule

// File: rtl/timing_wheel_reseq.sv
module timing_wheel_reseq #(
  parameter int ID_W  = 8,
  parameter int TS_W  = 6,   // must exceed log2(SLOTS)+1 so late and future differ
  parameter int SLOTS = 8,   // power of two
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            loose_i,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ID_W-1:0] in_id,
  input  logic [TS_W-1:0] in_ts,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ID_W-1:0] out_id,
  output logic            drop_o,
  output logic            overflow_o
);
  import rsq_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // Time and wheel state
  logic [TS_W-1:0]  now_q, now_nxt;
  logic [PTR_W-1:0] slot_hd [SLOTS];
  logic [PTR_W-1:0] slot_tl [SLOTS];
  logic [SLOTS-1:0] slot_ne;

  // Ready list, recycled pool, never-used counter
  logic [PTR_W-1:0] rdy_hd, rdy_tl, rec_hd;
  logic             rdy_ne;
  logic [CNT_W-1:0] rec_cnt, fresh_q;

  // Output registers
  logic             out_valid_q, drop_q, ovf_q;
  logic [ID_W-1:0]  out_id_q;

  // Control
  age_cls_t         cls;
  logic [SLOT_W-1:0] ins_slot, rel_slot;
  logic             pop_go, rel_go, ins_go, acc, place, room, have_rec;
  logic [PTR_W-1:0] alloc_ptr, rd_addr, rd_nx;
  logic [ID_W-1:0]  rd_id;
  logic             nx_we;
  logic [PTR_W-1:0] nx_wa, nx_wd;

  rsq_age_class #(.TS_W(TS_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cls (
    .now(now_q), .ts(in_ts), .cls(cls), .slot(ins_slot)
  );

  assign now_nxt  = now_q + TS_W'(1);
  assign rel_slot = now_nxt[SLOT_W-1:0];
  assign rel_go   = tick_i && slot_ne[rel_slot];

  // A tick owns the cycle, then a pop, then an insert
  assign pop_go   = !tick_i && rdy_ne && (!out_valid_q || out_ready);
  assign in_ready = !tick_i && !pop_go;
  assign acc      = in_valid && in_ready;

  assign have_rec  = (rec_cnt != '0);
  assign room      = have_rec || (fresh_q != CNT_W'(DEPTH));
  assign alloc_ptr = have_rec ? rec_hd : fresh_q[PTR_W-1:0];
  assign place     = (cls == AGE_ONTIME) || ((cls == AGE_LATE) && loose_i);
  assign ins_go    = acc && place && room;

  assign rd_addr = pop_go ? rdy_hd : rec_hd;

  // Single link-write port shared by splice, recycle and append
  always_comb begin
    nx_we = 1'b0;
    nx_wa = rdy_tl;
    nx_wd = slot_hd[rel_slot];
    if (rel_go && rdy_ne) begin
      nx_we = 1'b1;
    end else if (pop_go) begin
      nx_we = 1'b1;
      nx_wa = rdy_hd;
      nx_wd = rec_hd;
    end else if (ins_go && slot_ne[ins_slot]) begin
      nx_we = 1'b1;
      nx_wa = slot_tl[ins_slot];
      nx_wd = alloc_ptr;
    end
  end

  rsq_desc_mem #(.ID_W(ID_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk(clk),
    .id_we(ins_go), .id_wa(alloc_ptr), .id_wd(in_id),
    .nx_we(nx_we), .nx_wa(nx_wa), .nx_wd(nx_wd),
    .ra(rd_addr), .rd_id(rd_id), .rd_nx(rd_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q       <= '0;
      slot_ne     <= '0;
      rdy_ne      <= 1'b0;
      rec_cnt     <= '0;
      fresh_q     <= '0;
      out_valid_q <= 1'b0;
      drop_q      <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      drop_q <= acc && !(place && room);
      ovf_q  <= acc && place && !room;

      if (tick_i) begin
        now_q <= now_nxt;
        if (rel_go) begin
          slot_ne[rel_slot] <= 1'b0;
          rdy_tl            <= slot_tl[rel_slot];
          if (!rdy_ne) rdy_hd <= slot_hd[rel_slot];
          rdy_ne <= 1'b1;
        end
      end

      if (pop_go) begin
        out_valid_q <= 1'b1;
        out_id_q    <= rd_id;
        rdy_hd      <= rd_nx;
        if (rdy_hd == rdy_tl) rdy_ne <= 1'b0;
        rec_hd  <= rdy_hd;
        rec_cnt <= rec_cnt + CNT_W'(1);
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end

      if (ins_go) begin
        if (have_rec) begin
          rec_hd  <= rd_nx;
          rec_cnt <= rec_cnt - CNT_W'(1);
        end else begin
          fresh_q <= fresh_q + CNT_W'(1);
        end
        slot_tl[ins_slot] <= alloc_ptr;
        if (!slot_ne[ins_slot]) slot_hd[ins_slot] <= alloc_ptr;
        slot_ne[ins_slot] <= 1'b1;
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_id     = out_id_q;
  assign drop_o     = drop_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_i,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ID_W-1:0] out_id,
  input logic            drop_o,
  input logic            overflow_o
);
  // R4 / R6: a discard pulse only follows an accepted arrival
  assert_drop_follows_accept_R4: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> $past(in_valid && in_ready));

  // R7: an overflow is always reported as a discard too
  assert_ovf_implies_drop_R7: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> drop_o);

  // R9: a stalled output holds its cell
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

  // R10: no arrival is taken during a tick
  assert_tick_blocks_input_R10: assert property (@(posedge clk) disable iff (rst)
    tick_i |-> !in_ready);

  // R3: a presented cell carries a defined identifier
  assert_out_known_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_id));
endmodule

bind timing_wheel_reseq rsq_checker #(.ID_W(ID_W)) u_rsq_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_id(out_id), .drop_o(drop_o), .overflow_o(overflow_o)
);

// File: tb/tb_timing_wheel_reseq.sv
`timescale 1ns/1ps
module tb_timing_wheel_reseq;
  localparam int ID_W = 8, TS_W = 6, SLOTS = 8, DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, loose = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [ID_W-1:0] in_id = '0;
  logic [TS_W-1:0] in_ts = '0;
  logic in_ready, out_valid, drop_o, overflow_o;
  logic [ID_W-1:0] out_id;

  timing_wheel_reseq #(.ID_W(ID_W), .TS_W(TS_W), .SLOTS(SLOTS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .tick_i(tick), .loose_i(loose),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_ts(in_ts),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .drop_o(drop_o), .overflow_o(overflow_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Stimulus table: mode, id, age at insertion, expected discard
  typedef struct packed {
    logic              lz;
    logic [7:0]        id;
    logic signed [7:0] age;
    logic              drop;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd1,  8'sd0,  1'b0},   // R2 on time
    '{1'b0, 8'd2,  8'sd7,  1'b0},   // R2 last on-time age
    '{1'b0, 8'd3,  8'sd8,  1'b1},   // R4 strict late
    '{1'b0, 8'd4,  8'sd3,  1'b0},
    '{1'b0, 8'd5,  8'sd0,  1'b0},   // R3 same stamp as id 1
    '{1'b0, 8'd6,  -8'sd1, 1'b1},   // R6 future
    '{1'b0, 8'd7,  8'sd18, 1'b1},   // R6 too late
    '{1'b0, 8'd8,  8'sd7,  1'b0},
    '{1'b1, 8'd9,  8'sd8,  1'b0},   // R5 loose late joins slot of ids 1,5
    '{1'b1, 8'd10, 8'sd15, 1'b0},   // R5 loose, last late age
    '{1'b1, 8'd11, 8'sd16, 1'b1},   // R6 loose, too late
    '{1'b1, 8'd12, -8'sd3, 1'b1},   // R6 loose, future
    '{1'b1, 8'd13, 8'sd2,  1'b0}
  };

  int n_tests = 0, n_fail = 0;
  int now_abs = 0;
  int m_id [64], m_rel [64], m_n = 0;
  int exp_q [256], exp_n = 0;
  int log_q [256], log_n = 0, cmp_i = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst && out_valid && out_ready) begin
      log_q[log_n] = int'(out_id);
      log_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_exp();
    for (int i = 0; i < m_n; i++)
      if (m_rel[i] == now_abs) begin
        exp_q[exp_n] = m_id[i];
        exp_n++;
      end
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready during tick", int'(in_ready), 0);
    @(negedge clk);
    tick = 1'b0;
    now_abs++;
    push_exp();
  endtask

  task automatic settle_cmp();
    repeat (20) @(negedge clk);
    chk(log_n == exp_n, "R2", "released count", log_n, exp_n);
    for (int i = cmp_i; i < exp_n && i < log_n; i++)
      chk(log_q[i] == exp_q[i], "R3", "release order", log_q[i], exp_q[i]);
    cmp_i = exp_n;
  endtask

  task automatic send(int id, int ts, bit lz, bit exp_drop, bit exp_ovf, string req);
    int age;
    @(negedge clk);
    in_valid = 1'b1;
    in_id    = ID_W'(id);
    in_ts    = TS_W'(ts);
    loose    = lz;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(drop_o == exp_drop, req, "drop pulse", int'(drop_o), int'(exp_drop));
    chk(overflow_o == exp_ovf, req, "overflow pulse", int'(overflow_o), int'(exp_ovf));
    if (!exp_drop) begin
      age = now_abs - ts;
      m_id[m_n]  = id;
      m_rel[m_n] = (age >= SLOTS) ? ts + 2 * SLOTS : ts + SLOTS;
      m_n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d checks expected completion", n_tests);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(drop_o == 1'b0, "R1", "drop_o after reset", int'(drop_o), 0);
    chk(overflow_o == 1'b0, "R1", "overflow_o after reset", int'(overflow_o), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    for (int t = 0; t < 20; t++) do_tick();
    settle_cmp();

    // Table walk at time 20: R2, R4, R5, R6
    for (int v = 0; v < NV; v++)
      send(int'(VEC[v].id), now_abs - int'(VEC[v].age), VEC[v].lz, VEC[v].drop, 1'b0, "R4/R5/R6");
    loose = 1'b0;
    for (int t = 0; t < 10; t++) begin
      do_tick();
      settle_cmp();  // R2 nothing early, R3 and R5 ordering
    end

    // R10: an arrival offered during a tick is not taken
    @(negedge clk);
    in_valid = 1'b1; in_id = 8'd200; in_ts = TS_W'(now_abs); tick = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready with tick and arrival", int'(in_ready), 0);
    @(negedge clk);
    tick = 1'b0; in_valid = 1'b0;
    now_abs++;
    push_exp();
    chk(drop_o == 1'b0, "R10", "no discard for refused arrival", int'(drop_o), 0);
    settle_cmp();

    // R7: fill every descriptor, then one more
    for (int i = 0; i < DEPTH; i++)
      send(100 + i, now_abs - (i % SLOTS), 1'b0, 1'b0, 1'b0, "R7 fill");
    send(150, now_abs, 1'b0, 1'b1, 1'b1, "R7 overflow");
    for (int t = 0; t < SLOTS; t++) begin
      do_tick();
      settle_cmp();
    end

    // R8: recycled descriptors carry new cells
    for (int i = 0; i < 4; i++)
      send(160 + i, now_abs, 1'b0, 1'b0, 1'b0, "R8 reuse");
    for (int t = 0; t < SLOTS; t++) begin
      do_tick();
      settle_cmp();
    end
    chk(log_n == 8 + DEPTH + 4, "R8", "total cells passed", log_n, 8 + DEPTH + 4);

    // R9: stalled output keeps its cell
    send(170, now_abs - (SLOTS - 1), 1'b0, 1'b0, 1'b0, "R9 setup");
    send(171, now_abs - (SLOTS - 1), 1'b0, 1'b0, 1'b0, "R9 setup");
    out_ready = 1'b0;
    do_tick();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R9", "out_valid under stall", int'(out_valid), 1);
    chk(out_id == 8'd170, "R9", "out_id under stall", int'(out_id), 170);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b1, "R9", "out_valid held", int'(out_valid), 1);
    chk(out_id == 8'd170, "R9", "out_id held", int'(out_id), 170);
    out_ready = 1'b1;
    settle_cmp();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule